// File: doc/BRIEF.md
# Prioritized Interrupt Request and Acknowledge Unit

This unit sits between a processor core and its interrupt request lines: a single-cycle exception pulse from the core, one active-low non-maskable pin and four active-low maskable pins. The maskable pins are asynchronous to the core clock, so they are resynchronized. The non-maskable pin is edge-latched. One fixed-priority pick chooses which pending source is taken next. For a maskable source, the unit runs one acknowledge cycle on the address bus. During that cycle every address line is high except the one line that names the source.

Once the source is accepted, the unit holds it in service and presents the address of the memory word that holds the handler's start address. That fetch address is built from the vectoring mode chosen for maskable line 0, the vector word returned by the device during the acknowledge cycle, an 8-bit table-page register and a 16-bit upper-address extension register. The unit also reports how wide the table read must be and how wide the return-address save must be, both set by the core's narrow/wide operating mode. The unit stays in service until the core pulses a done handshake.

Top module: `irq_ack_unit`

## Requirements
- R1: Each maskable pin passes through a two-flop synchronizer. A low (asserted) maskable pin is accepted only while the global enable flag is set and its `int_mask_i` bit is 0; a mask bit of 1 blocks that pin. Clearing a mask bit lets an already-synchronized request be accepted on the next clock edge.
- R2: When several sources are pending, they are accepted in this fixed order, highest first: core exception, non-maskable, maskable 0, 1, 2, 3. `src_o` encodes none=0, exception=1, non-maskable=2, maskable 0..3 = 3..6.
- R3: Accepting maskable source n is followed by exactly one cycle with `ack_active_o`=1, in which `ack_addr_o` is all ones except bit n, which is 0. Service starts on the next cycle. In every other cycle `ack_addr_o` is all ones, and exception or non-maskable acceptance has no acknowledge cycle.
- R4: A falling edge on `nmi_ni`, after synchronization, sets a pending flag. The flag stays set until the source is accepted, even if the pin goes high again. The non-maskable source ignores the enable flag and the masks.
- R5: Maskable 0 in vector mode 2 (`int0_mode_i`=2): `fetch_addr_o[15:0]` = {`ireg_i`, `vec_i[7:1]`, 0}.
- R6: Maskable 0 in vector mode 3: `fetch_addr_o[15:0]` = {`vec_i[15:1]`, 0}. The vector is the full 16-bit device word.
- R7: Maskables 1, 2 and 3 always use assigned slots, whatever mode is set for maskable 0: `fetch_addr_o[15:0]` = {`ireg_i`, 8'h02 / 8'h04 / 8'h06}.
- R8: Whenever `fetch_valid_o`=1, `fetch_addr_o[31:16]` equals `iext_i` and `fetch_addr_o[0]` is 0. The device vector is the value on `vec_i` during the acknowledge cycle.
- R9: Maskable 0 in modes 0 and 1, the non-maskable source and the exception need no table read: `fetch_valid_o` stays 0 during their service.
- R10: `ext_mode_i` is sampled at acceptance. During service, `push_wide_o` equals that sample (1 = 32-bit return save, 0 = 16-bit). `fetch_wide_o` equals it whenever `fetch_valid_o`=1.
- R11: The global enable flag is 0 after reset and is set by a one-cycle `ei_i` pulse. Accepting any source clears it. `serve_o` and `src_o` hold until `ack_done_i`, and the unit is idle one cycle later.
- R12: An `trap_i` pulse is accepted whatever the enable flag and the masks are, two clock edges after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_i | input | 1 | One-cycle exception pulse from the core |
| nmi_ni | input | 1 | Non-maskable request pin, active low, edge-sensitive |
| int_ni | input | 4 | Maskable request pins, active low, asynchronous levels |
| int_mask_i | input | 4 | Per-pin block bits, 1 = blocked |
| ei_i | input | 1 | One-cycle pulse that sets the global enable flag |
| int0_mode_i | input | 2 | Vectoring mode for maskable 0 (0..3) |
| ext_mode_i | input | 1 | Core operating width, 1 = wide (32-bit) |
| ireg_i | input | 8 | Vector table page register |
| iext_i | input | 16 | Upper-address extension register |
| vec_i | input | 16 | Vector word from the data bus during acknowledge |
| ack_done_i | input | 1 | One-cycle handshake closing the service |
| ack_active_o | output | 1 | Acknowledge cycle in progress |
| ack_addr_o | output | 32 | Acknowledge address, one line low |
| serve_o | output | 1 | Source accepted and in service |
| src_o | output | 3 | Accepted source code |
| fetch_valid_o | output | 1 | A start-address table read is required |
| fetch_addr_o | output | 32 | Table read address |
| fetch_wide_o | output | 1 | Table read is 32 bits (else 16) |
| push_wide_o | output | 1 | Return-address save is 32 bits (else 16) |

## Verification
A maskable pin driven low between edges has its acknowledge cycle after the third edge and enters service after the fourth. A non-maskable falling edge also enters service after the fourth edge, with no acknowledge cycle. An exception pulse enters service after the second edge. Clearing a mask bit over an already-synchronized request gives service after the second edge, and an enable pulse over a waiting request gives service after the third. The driver records the cycle count at each stimulus with the expected latency. The monitor samples on the falling clock edge, measures the cycle count when `serve_o` rises, and compares it, the acknowledge address and the fetch fields against the queued item. Where several sources queue behind each other, only their order and fields are compared, not their latency.

// File: rtl/irq_pkg.sv
package irq_pkg;

    // Source codes, ordered so that a lower code is a higher priority
    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_TRAP = 3'd1,
        SRC_NMI  = 3'd2,
        SRC_INT0 = 3'd3,
        SRC_INT1 = 3'd4,
        SRC_INT2 = 3'd5,
        SRC_INT3 = 3'd6
    } irq_src_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACK   = 2'd1,
        ST_SERVE = 2'd2
    } irq_state_e;

    typedef enum logic [1:0] {
        VM_0 = 2'd0,
        VM_1 = 2'd1,
        VM_2 = 2'd2,
        VM_3 = 2'd3
    } vec_mode_e;

    localparam int MAX_MASKABLE = 4;

endpackage

// File: rtl/irq_input_cond.sv
module irq_input_cond #(
    parameter int NUM_MASK    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                trap_i,
    input  logic                nmi_ni,
    input  logic [NUM_MASK-1:0] int_ni,
    input  logic                trap_clr_i,
    input  logic                nmi_clr_i,
    output logic                trap_pend_o,
    output logic                nmi_pend_o,
    output logic [NUM_MASK-1:0] int_req_o
);

    localparam int NMI_TAPS = SYNC_STAGES + 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0][NUM_MASK-1:0] isync;
        logic [NMI_TAPS-1:0]                  nsync;
        logic                                 trap_pend;
        logic                                 nmi_pend;
    } cond_t;

    cond_t cond_d, cond_q;
    logic  nmi_fall;

    always_comb begin
        cond_d          = cond_q;
        cond_d.isync[0] = int_ni;
        for (int s = 1; s < SYNC_STAGES; s++) begin
            cond_d.isync[s] = cond_q.isync[s-1];
        end
        cond_d.nsync     = {cond_q.nsync[NMI_TAPS-2:0], nmi_ni};
        // high in the older tap, low in the newer one: a falling edge
        nmi_fall         = cond_q.nsync[NMI_TAPS-1] & ~cond_q.nsync[NMI_TAPS-2];
        cond_d.nmi_pend  = nmi_fall | (cond_q.nmi_pend & ~nmi_clr_i);
        cond_d.trap_pend = trap_i | (cond_q.trap_pend & ~trap_clr_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cond_q <= '{isync: '1, nsync: '1, trap_pend: 1'b0, nmi_pend: 1'b0};
        end else begin
            cond_q <= cond_d;
        end
    end

    assign trap_pend_o = cond_q.trap_pend;
    assign nmi_pend_o  = cond_q.nmi_pend;
    assign int_req_o   = ~cond_q.isync[SYNC_STAGES-1];

    // R4: a pending non-maskable request survives until it is taken
    assert_nmi_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (nmi_pend_o && !nmi_clr_i) |=> nmi_pend_o);

    // R12: an exception pulse is always recorded
    assert_trap_latched_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_i |=> trap_pend_o);

endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
    import irq_pkg::*;
#(
    parameter int NUM_MASK = 4
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                trap_pend_i,
    input  logic                nmi_pend_i,
    input  logic [NUM_MASK-1:0] int_req_i,
    input  logic [NUM_MASK-1:0] int_mask_i,
    input  logic                ien_i,
    output irq_src_e            win_o
);

    localparam int GRANT_W = NUM_MASK + 2;

    logic [NUM_MASK-1:0] eligible;
    logic [GRANT_W-1:0]  grant;
    logic                found;
    int                  pick;

    assign eligible = int_req_i & ~int_mask_i & {NUM_MASK{ien_i}};

    always_comb begin
        grant = '0;
        win_o = SRC_NONE;
        found = 1'b0;
        pick  = 0;
        // scan from the lowest priority so the lowest index wins
        for (int k = NUM_MASK - 1; k >= 0; k--) begin
            if (eligible[k]) begin
                found = 1'b1;
                pick  = k;
            end
        end
        if (trap_pend_i) begin
            grant[0] = 1'b1;
            win_o    = SRC_TRAP;
        end else if (nmi_pend_i) begin
            grant[1] = 1'b1;
            win_o    = SRC_NMI;
        end else if (found) begin
            grant[2 + pick] = 1'b1;
            win_o           = irq_src_e'(3'(SRC_INT0) + 3'(pick));
        end
    end

    // R2: never more than one source granted
    assert_grant_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(grant));

    // R1: a maskable winner needs the enable flag
    assert_masked_needs_enable_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (win_o >= SRC_INT0) |-> ien_i);

endmodule

// File: rtl/irq_fetch_gen.sv
module irq_fetch_gen
    import irq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int VEC_W  = 16
) (
    input  logic              active_i,
    input  irq_src_e          src_i,
    input  vec_mode_e         mode_i,
    input  logic              wide_i,
    input  logic [VEC_W-9:0]  ireg_i,
    input  logic [ADDR_W-VEC_W-1:0] iext_i,
    input  logic [VEC_W-1:0]  vec_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wide_o
);

    logic [VEC_W-1:0] low;
    logic [7:0]       slot_off;
    logic [2:0]       slot_idx;

    always_comb begin
        slot_idx = 3'(src_i - SRC_INT0);
        slot_off = {4'd0, slot_idx, 1'b0};
        low      = '0;
        valid_o  = 1'b0;
        if (active_i) begin
            unique case (src_i)
                SRC_INT0: begin
                    unique case (mode_i)
                        VM_2: begin
                            low     = {ireg_i, vec_i[7:0] & 8'hFE};
                            valid_o = 1'b1;
                        end
                        VM_3: begin
                            low     = vec_i & ~VEC_W'(1);
                            valid_o = 1'b1;
                        end
                        default: ;
                    endcase
                end
                SRC_INT1, SRC_INT2, SRC_INT3: begin
                    low     = {ireg_i, slot_off};
                    valid_o = 1'b1;
                end
                default: ;
            endcase
        end
        addr_o = {iext_i, low};
        wide_o = valid_o & wide_i;
    end

endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit
    import irq_pkg::*;
#(
    parameter int NUM_MASK    = 4,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 32,
    parameter int VEC_W       = 16
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    trap_i,
    input  logic                    nmi_ni,
    input  logic [NUM_MASK-1:0]     int_ni,
    input  logic [NUM_MASK-1:0]     int_mask_i,
    input  logic                    ei_i,
    input  logic [1:0]              int0_mode_i,
    input  logic                    ext_mode_i,
    input  logic [VEC_W-9:0]        ireg_i,
    input  logic [ADDR_W-VEC_W-1:0] iext_i,
    input  logic [VEC_W-1:0]        vec_i,
    input  logic                    ack_done_i,
    output logic                    ack_active_o,
    output logic [ADDR_W-1:0]       ack_addr_o,
    output logic                    serve_o,
    output logic [2:0]              src_o,
    output logic                    fetch_valid_o,
    output logic [ADDR_W-1:0]       fetch_addr_o,
    output logic                    fetch_wide_o,
    output logic                    push_wide_o
);

    // NUM_MASK may not exceed MAX_MASKABLE: the source code space has four maskable slots

    typedef struct packed {
        irq_state_e       st;
        irq_src_e         src;
        vec_mode_e        mode;
        logic             wide;
        logic             ien;
        logic [VEC_W-1:0] vec;
    } ctl_t;

    ctl_t     ctl_d, ctl_q;
    irq_src_e win;
    logic     trap_pend, nmi_pend, trap_clr, nmi_clr;
    logic [NUM_MASK-1:0] int_req;
    logic [2:0] ack_idx;

    irq_input_cond #(
        .NUM_MASK   (NUM_MASK),
        .SYNC_STAGES(SYNC_STAGES)
    ) cond_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .trap_i     (trap_i),
        .nmi_ni     (nmi_ni),
        .int_ni     (int_ni),
        .trap_clr_i (trap_clr),
        .nmi_clr_i  (nmi_clr),
        .trap_pend_o(trap_pend),
        .nmi_pend_o (nmi_pend),
        .int_req_o  (int_req)
    );

    irq_prio_arb #(
        .NUM_MASK(NUM_MASK)
    ) arb_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .trap_pend_i(trap_pend),
        .nmi_pend_i (nmi_pend),
        .int_req_i  (int_req),
        .int_mask_i (int_mask_i),
        .ien_i      (ctl_q.ien),
        .win_o      (win)
    );

    always_comb begin
        ctl_d    = ctl_q;
        trap_clr = 1'b0;
        nmi_clr  = 1'b0;
        if (ei_i) ctl_d.ien = 1'b1;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (win != SRC_NONE) begin
                    ctl_d.src  = win;
                    ctl_d.mode = vec_mode_e'(int0_mode_i);
                    ctl_d.wide = ext_mode_i;
                    ctl_d.ien  = 1'b0;
                    ctl_d.st   = (win >= SRC_INT0) ? ST_ACK : ST_SERVE;
                    trap_clr   = (win == SRC_TRAP);
                    nmi_clr    = (win == SRC_NMI);
                end
            end
            ST_ACK: begin
                ctl_d.vec = vec_i;
                ctl_d.st  = ST_SERVE;
            end
            ST_SERVE: begin
                if (ack_done_i) begin
                    ctl_d.st  = ST_IDLE;
                    ctl_d.src = SRC_NONE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '{st: ST_IDLE, src: SRC_NONE, mode: VM_0, wide: 1'b0,
                       ien: 1'b0, vec: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ack_active_o = (ctl_q.st == ST_ACK);
    assign ack_idx      = 3'(ctl_q.src - SRC_INT0);
    assign ack_addr_o   = ack_active_o ? ~(ADDR_W'(1) << ack_idx) : '1;
    assign serve_o      = (ctl_q.st == ST_SERVE);
    assign src_o        = ctl_q.src;
    assign push_wide_o  = serve_o & ctl_q.wide;

    irq_fetch_gen #(
        .ADDR_W(ADDR_W),
        .VEC_W (VEC_W)
    ) fetch_i (
        .active_i(serve_o),
        .src_i   (ctl_q.src),
        .mode_i  (ctl_q.mode),
        .wide_i  (ctl_q.wide),
        .ireg_i  (ireg_i),
        .iext_i  (iext_i),
        .vec_i   (ctl_q.vec),
        .valid_o (fetch_valid_o),
        .addr_o  (fetch_addr_o),
        .wide_o  (fetch_wide_o)
    );

    // R3: exactly one address line low during acknowledge, within the maskable field
    assert_ack_onecold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_active_o |-> ($countones(ack_addr_o) == ADDR_W - 1) &&
                         (&ack_addr_o[ADDR_W-1:NUM_MASK]));

    // R3: the acknowledge cycle lasts one cycle and leads into service
    assert_ack_then_serve_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_active_o |=> serve_o && !ack_active_o);

    // R8: table reads keep the extension register on the upper half and stay even
    assert_fetch_upper_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fetch_valid_o |-> (fetch_addr_o[ADDR_W-1:VEC_W] == iext_i) && !fetch_addr_o[0]);

    // R11: taking a source clears the enable flag
    assert_accept_disables_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.st == ST_IDLE && win != SRC_NONE) |=> !ctl_q.ien);

    // R11: service holds its source until the done handshake
    assert_serve_holds_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (serve_o && !ack_done_i) |=> serve_o && $stable(src_o));

    // R10: return save width stays fixed through service
    assert_push_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (serve_o && !ack_done_i) |=> $stable(push_wide_o));

endmodule

// File: tb/irq_ack_unit_tb_top.sv
`timescale 1ns/1ps
module irq_ack_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap = 1'b0;
    logic        nmi_n = 1'b1;
    logic [3:0]  int_n = 4'hF;
    logic [3:0]  mask = 4'h0;
    logic        ei = 1'b0;
    logic [1:0]  mode = 2'd2;
    logic        ext = 1'b0;
    logic [7:0]  ireg = 8'h5A;
    logic [15:0] iext = 16'h1234;
    logic [15:0] vec = 16'h00C7;
    logic        ack_done = 1'b0;

    logic        ack_active, serve, fetch_valid, fetch_wide, push_wide;
    logic [31:0] ack_addr, fetch_addr;
    logic [2:0]  src;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    irq_ack_unit dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .trap_i       (trap),
        .nmi_ni       (nmi_n),
        .int_ni       (int_n),
        .int_mask_i   (mask),
        .ei_i         (ei),
        .int0_mode_i  (mode),
        .ext_mode_i   (ext),
        .ireg_i       (ireg),
        .iext_i       (iext),
        .vec_i        (vec),
        .ack_done_i   (ack_done),
        .ack_active_o (ack_active),
        .ack_addr_o   (ack_addr),
        .serve_o      (serve),
        .src_o        (src),
        .fetch_valid_o(fetch_valid),
        .fetch_addr_o (fetch_addr),
        .fetch_wide_o (fetch_wide),
        .push_wide_o  (push_wide)
    );

    typedef struct {
        int          src;
        int          ack_bit;
        bit          fv;
        logic [31:0] addr;
        bit          wide;
        int          lat;
        int          t0;
        string       req;
    } exp_t;

    exp_t sb_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic push_exp(input int s, input int ab, input bit fv,
                            input logic [31:0] a, input bit w, input int lat,
                            input string req);
        exp_t e;
        e.src = s; e.ack_bit = ab; e.fv = fv; e.addr = a; e.wide = w;
        e.lat = lat; e.t0 = cyc; e.req = req;
        sb_q.push_back(e);
    endtask

    // monitor: compares acknowledge and service results against the queue
    logic ack_prev = 1'b0, serve_prev = 1'b0;
    exp_t cur;
    logic [31:0] exp_ack;
    always @(negedge clk) begin
        if (rst_n) begin
            if (ack_active && !ack_prev) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R3", "unexpected ack", ack_addr, 32'hFFFFFFFF);
                end else begin
                    cur = sb_q[0];
                    exp_ack = (cur.ack_bit < 0) ? 32'hFFFFFFFF : ~(32'd1 << cur.ack_bit);
                    chk(cur.ack_bit >= 0 && ack_addr == exp_ack, "R3",
                        {"ack address for ", cur.req}, ack_addr, exp_ack);
                end
            end
            if (serve && !serve_prev) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R11", "unexpected service", 32'(src), 32'd0);
                end else begin
                    cur = sb_q.pop_front();
                    chk(int'(src) == cur.src, cur.req, "source", 32'(src), 32'(cur.src));
                    chk(fetch_valid == cur.fv, cur.req, "fetch valid",
                        32'(fetch_valid), 32'(cur.fv));
                    if (cur.fv) begin
                        chk(fetch_addr == cur.addr, cur.req, "fetch address",
                            fetch_addr, cur.addr);
                    end
                    chk(fetch_wide == (cur.fv & cur.wide), "R10", "fetch width",
                        32'(fetch_wide), 32'(cur.fv & cur.wide));
                    chk(push_wide == cur.wide, "R10", "push width",
                        32'(push_wide), 32'(cur.wide));
                    if (cur.lat >= 0) begin
                        chk(cyc - cur.t0 == cur.lat, cur.req, "latency",
                            32'(cyc - cur.t0), 32'(cur.lat));
                    end
                end
            end
        end
        ack_prev   <= ack_active;
        serve_prev <= serve;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ei();
        ei = 1'b1;
        @(negedge clk);
        ei = 1'b0;
    endtask

    task automatic wait_serve(input string req);
        int w = 0;
        while (!serve && w < 60) begin
            @(negedge clk);
            w++;
        end
        if (w == 60) chk(1'b0, req, "service timeout", 32'd0, 32'd1);
    endtask

    task automatic done_pulse();
        ack_done = 1'b1;
        @(negedge clk);
        ack_done = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // reset state: R3 idle bus all ones, R11 idle
        chk(ack_addr == 32'hFFFFFFFF, "R3", "idle ack address", ack_addr, 32'hFFFFFFFF);
        chk(!serve && !ack_active, "R11", "idle after reset", 32'(serve), 32'd0);
        chk(src == 3'd0 && !fetch_valid, "R9", "no source after reset", 32'(src), 32'd0);

        // R11: enable starts cleared, a waiting request is not taken
        int_n = 4'b1110;
        tick(8);
        chk(!serve && !ack_active, "R11", "enable clear after reset", 32'(serve), 32'd0);
        int_n = 4'hF;
        tick(3);

        // R5: maskable 0, mode 2, narrow
        pulse_ei();
        mode = 2'd2; ext = 1'b0; vec = 16'h00C7;
        int_n = 4'b1110;
        push_exp(3, 0, 1'b1, 32'h12345AC6, 1'b0, 4, "R5");
        wait_serve("R5"); done_pulse();
        int_n = 4'hF; tick(3);

        // R6 and R8: mode 3 with a 16-bit odd vector, wide
        pulse_ei();
        mode = 2'd3; ext = 1'b1; vec = 16'hBEEF;
        int_n = 4'b1110;
        push_exp(3, 0, 1'b1, 32'h1234BEEE, 1'b1, 4, "R6 R8");
        wait_serve("R6"); done_pulse();
        int_n = 4'hF; tick(3);

        // R7: maskable 2 uses its assigned slot even with mode 3 selected
        pulse_ei();
        mode = 2'd3; ext = 1'b0; iext = 16'hA0B1;
        int_n = 4'b1011;
        push_exp(5, 2, 1'b1, 32'hA0B15A04, 1'b0, 4, "R7");
        wait_serve("R7"); done_pulse();
        int_n = 4'hF; iext = 16'h1234; tick(3);

        // R9: maskable 0 in mode 1 needs no table read
        pulse_ei();
        mode = 2'd1;
        int_n = 4'b1110;
        push_exp(3, 0, 1'b0, 32'h0, 1'b0, 4, "R9");
        wait_serve("R9"); done_pulse();
        int_n = 4'hF; tick(3);

        // R1: a masked request waits, then is taken the edge after unmasking
        pulse_ei();
        mask = 4'b0010;
        int_n = 4'b1101;
        tick(10);
        chk(!serve && !ack_active, "R1", "masked request ignored", 32'(serve), 32'd0);
        mask = 4'b0000;
        push_exp(4, 1, 1'b1, 32'h12345A02, 1'b0, 2, "R1");
        wait_serve("R1"); done_pulse();
        int_n = 4'hF; tick(3);

        // R11: enable cleared by the previous acceptance; enable pulse releases it
        int_n = 4'b0111;
        tick(10);
        chk(!serve && !ack_active, "R11", "request held off while disabled", 32'(serve), 32'd0);
        ei = 1'b1;
        push_exp(6, 3, 1'b1, 32'h12345A06, 1'b0, 3, "R11");
        @(negedge clk);
        ei = 1'b0;
        wait_serve("R11");
        tick(5);
        chk(serve && src == 3'd6, "R11", "service held without done", 32'(src), 32'd6);
        done_pulse();
        chk(!serve && src == 3'd0, "R11", "idle after done", 32'(src), 32'd0);
        int_n = 4'hF; tick(3);

        // R4 and R10: short non-maskable edge with enable clear, wide mode
        ext = 1'b1;
        nmi_n = 1'b0;
        push_exp(2, -1, 1'b0, 32'h0, 1'b1, 4, "R4");
        tick(2);
        nmi_n = 1'b1;
        wait_serve("R4"); done_pulse();
        tick(3);

        // R12: exception with enable clear
        trap = 1'b1;
        push_exp(1, -1, 1'b0, 32'h0, 1'b1, 2, "R12");
        @(negedge clk);
        trap = 1'b0;
        wait_serve("R12"); done_pulse();
        tick(3);

        // R2: all sources together, order exception, non-maskable, 1, 3
        ext = 1'b0; mode = 2'd2;
        pulse_ei();
        trap = 1'b1; nmi_n = 1'b0; int_n = 4'b0101;
        push_exp(1, -1, 1'b0, 32'h0, 1'b0, 2, "R2");
        push_exp(2, -1, 1'b0, 32'h0, 1'b0, -1, "R2");
        push_exp(4, 1, 1'b1, 32'h12345A02, 1'b0, -1, "R2");
        push_exp(6, 3, 1'b1, 32'h12345A06, 1'b0, -1, "R2");
        @(negedge clk);
        trap = 1'b0;
        wait_serve("R2"); done_pulse();
        nmi_n = 1'b1;
        wait_serve("R2"); done_pulse();
        tick(2);
        chk(!serve, "R2", "maskables wait for enable", 32'(serve), 32'd0);
        pulse_ei();
        wait_serve("R2");
        int_n = 4'b0111;
        done_pulse();
        tick(3);
        pulse_ei();
        wait_serve("R2"); done_pulse();
        int_n = 4'hF;
        tick(5);

        chk(sb_q.size() == 0, "R2", "all expected services seen",
            32'(sb_q.size()), 32'd0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule